// File: doc/BRIEF.md
# Broadcast Link Word Serializer

This block is the sending half of one endpoint on a shared broadcast link. A core hands it a 32-bit word, a 3-bit message kind and a 4-bit stream tag through a valid/ready handshake. The block pushes the word onto a lane bundle whose width is fixed at elaboration to 32, 16, 8 or 4 bits. A narrower bundle splits the word into 1, 2, 4 or 8 consecutive sub-word beats, lowest bits first. The kind and tag ride on sideband lines beside the data and stay put for every beat of the word. A forwarded strobe tells receivers which cycles carry a valid beat, and a first-beat flag marks where a word starts.

Receivers that fall behind raise a throttle line. While it is high the block keeps the current beat on the lanes, drops the strobe and does not advance. Once the line falls, sending resumes from that same beat. A word that is being sent does not block the next one: the next word can be accepted in the cycle that the last beat leaves. At full width this gives one word per clock.

Control is one state machine with two states. IDLE means nothing is held; the block is ready and leaves on an accepted word (IDLE to SEND). SEND presents the held word. It stays in SEND while throttled, on each beat that is not the last, and on a last beat that goes out together with a newly accepted word. It returns to IDLE when the last beat goes out and no new word is offered.

Top module: `bcast_word_ser`

## Requirements
- R1: While reset is asserted and whenever no word is held, in_ready is 1, lane_strobe and lane_first are 0, and lane_data, lane_kind and lane_tag are all zero.
- R2: The parameter LANES is one of 32, 16, 8 or 4, and a word takes 32/LANES beats. With in_valid held high and throttle low, a word is accepted every 32/LANES cycles. At LANES=32 that is every cycle.
- R3: Beat i of a word carries bits [i*LANES +: LANES] of the accepted in_word, least significant sub-word first. Beat 0 appears in the cycle right after the rising edge that accepted the word.
- R4: lane_strobe is 1 exactly in the cycles in which a word is held and throttle is 0. Each strobed beat is the next beat of the word, so no beat is skipped or repeated.
- R5: While a word is held and throttle is 1, lane_strobe is 0 and lane_data, lane_first, lane_kind and lane_tag keep their values. After throttle falls, the same beat is presented again with the strobe high.
- R6: lane_kind and lane_tag equal the in_kind and in_tag sampled with the word, on every beat of that word. Kind codes are 0 raw data, 1 cache read, 2 cache write, 3 barrier and 4 ping; other values are carried unchanged. The tag is 4 bits wide.
- R7: lane_first is 1 on beat 0 of each word and 0 on every other beat.
- R8: While a word is held, in_ready is 0, except in the cycle in which its last beat is strobed. In that cycle in_ready is 1, and a word offered then is accepted at the same edge with no idle cycle between the two words.
- R9: in_word, in_kind and in_tag have no effect unless in_valid and in_ready are both 1 at a rising edge. A held word's lanes and sideband do not change when these inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered by the core |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_word | input | 32 | Payload word |
| in_kind | input | 3 | Message kind code (R6) |
| in_tag | input | 4 | Stream tag |
| throttle | input | 1 | Backpressure from receivers; holds the current beat |
| lane_data | output | LANES | Current sub-word beat |
| lane_strobe | output | 1 | Forwarded strobe: a beat is launched this cycle |
| lane_first | output | 1 | The presented beat is beat 0 of its word |
| lane_kind | output | 3 | Sideband kind of the held word |
| lane_tag | output | 4 | Sideband tag of the held word |

## Verification
The first beat of an accepted word is due one cycle after the accepting edge. in_ready, lane_strobe and the hold on throttle react within the same cycle, because throttle reaches them without a register. Each beat advances one cycle after a strobed cycle. The bench drives all inputs at the falling edge and samples the outputs one nanosecond later. There it compares them against a queue-free behavioural model. The model is advanced only after that comparison, so every expectation refers to the state produced by the previous rising edge. Two widths, 8 and 32 lanes, are run side by side, and both go through free-running, sparse, periodic and random throttle patterns.

// File: rtl/bws_pkg.sv
package bws_pkg;
    localparam int WORD_W = 32;
    localparam int KIND_W = 3;
    localparam int TAG_W  = 4;

    typedef enum logic [KIND_W-1:0] {
        KIND_RAW   = 3'd0,
        KIND_CRD   = 3'd1,
        KIND_CWR   = 3'd2,
        KIND_BAR   = 3'd3,
        KIND_PING  = 3'd4
    } msg_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ser_state_e;
endpackage

// File: rtl/bws_beat_cnt.sv
module bws_beat_cnt #(
    parameter int BEATS = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             step,
    output logic [CNT_W-1:0] idx,
    output logic             at_last,
    output logic             is_first
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= '0;
        end else if (step && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx      = cnt_q;
    assign at_last  = (cnt_q == LAST_IDX);
    assign is_first = (cnt_q == '0);
endmodule

// File: rtl/bws_word_hold.sv
module bws_word_hold
    import bws_pkg::*;
#(
    parameter int LANES = 8,
    parameter int BEATS = 4,
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] in_word,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [CNT_W-1:0]  idx,
    output logic [LANES-1:0]  beat_data,
    output logic [KIND_W-1:0] held_kind,
    output logic [TAG_W-1:0]  held_tag
);
    localparam int SLOTS = 1 << CNT_W;

    logic [WORD_W-1:0] word_q;
    logic [KIND_W-1:0] kind_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LANES-1:0]  slot [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            kind_q <= '0;
            tag_q  <= '0;
        end else if (take) begin
            word_q <= in_word;
            kind_q <= in_kind;
            tag_q  <= in_tag;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < BEATS) begin : g_used
            assign slot[g] = word_q[g*LANES +: LANES];
        end else begin : g_pad
            assign slot[g] = '0;
        end
    end

    assign beat_data = slot[idx];
    assign held_kind = kind_q;
    assign held_tag  = tag_q;
endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
    import bws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic throttle,
    input  logic at_last,
    output logic in_ready,
    output logic busy,
    output logic strobe,
    output logic step,
    output logic take
);
    ser_state_e state_q;
    ser_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        in_ready = 1'b0;
        busy     = 1'b0;
        strobe   = 1'b0;
        step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                busy     = 1'b1;
                strobe   = !throttle;
                step     = !throttle;
                in_ready = at_last && !throttle;
                if (at_last && !throttle) begin
                    state_nx = in_valid ? ST_SEND : ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign take = in_valid && in_ready;
endmodule

// File: rtl/bcast_word_ser.sv
module bcast_word_ser
    import bws_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    input  logic [2:0]        in_kind,
    input  logic [3:0]        in_tag,
    input  logic              throttle,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_strobe,
    output logic              lane_first,
    output logic [2:0]        lane_kind,
    output logic [3:0]        lane_tag
);
    localparam int BEATS = WORD_W / LANES;
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic             busy;
    logic             step;
    logic             take;
    logic             at_last;
    logic             is_first;
    logic             strobe;
    logic [CNT_W-1:0] idx;
    logic [LANES-1:0] beat_data;
    logic [KIND_W-1:0] held_kind;
    logic [TAG_W-1:0]  held_tag;

    bws_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .throttle (throttle),
        .at_last  (at_last),
        .in_ready (in_ready),
        .busy     (busy),
        .strobe   (strobe),
        .step     (step),
        .take     (take)
    );

    bws_beat_cnt #(
        .BEATS (BEATS),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .step     (step),
        .idx      (idx),
        .at_last  (at_last),
        .is_first (is_first)
    );

    bws_word_hold #(
        .LANES (LANES),
        .BEATS (BEATS),
        .CNT_W (CNT_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .in_word   (in_word),
        .in_kind   (in_kind),
        .in_tag    (in_tag),
        .idx       (idx),
        .beat_data (beat_data),
        .held_kind (held_kind),
        .held_tag  (held_tag)
    );

    // Idle lanes are driven to zero (R1)
    assign lane_data   = busy ? beat_data : '0;
    assign lane_kind   = busy ? held_kind : '0;
    assign lane_tag    = busy ? held_tag  : '0;
    assign lane_first  = busy && is_first;
    assign lane_strobe = strobe;
endmodule

// File: rtl/bcast_word_ser_chk.sv
module bcast_word_ser_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             throttle,
    input logic             busy,
    input logic [LANES-1:0] lane_data,
    input logic             lane_strobe,
    input logic             lane_first,
    input logic [2:0]       lane_kind,
    input logic [3:0]       lane_tag
);
    // R2: only the four supported widths
    initial begin
        a_r2_lane_width: assert (LANES == 32 || LANES == 16 || LANES == 8 || LANES == 4)
            else $error("unsupported LANES %0d", LANES);
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_data == '0 && !lane_first && !lane_strobe && lane_kind == '0 && lane_tag == '0 && in_ready));

    a_r4_no_strobe_when_throttled: assert property (@(posedge clk) disable iff (!rst_n)
        lane_strobe |-> !throttle);

    a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle && !in_ready) |=> ($stable(lane_data) && $stable(lane_first) && $stable(lane_kind) && $stable(lane_tag)));

    a_r6_sideband_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lane_first) |-> ($stable(lane_kind) && $stable(lane_tag)));

    a_r7_first_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> lane_first);

    a_r8_mid_word_not_first: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_strobe && !in_ready) |=> (busy && !lane_first));
endmodule

bind bcast_word_ser bcast_word_ser_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .throttle    (throttle),
    .busy        (busy),
    .lane_data   (lane_data),
    .lane_strobe (lane_strobe),
    .lane_first  (lane_first),
    .lane_kind   (lane_kind),
    .lane_tag    (lane_tag)
);

// File: tb/bcast_word_ser_tb.sv
`timescale 1ns/1ps

module bcast_word_ser_run #(
    parameter int L    = 8,
    parameter int SEED = 1,
    parameter int N    = 1000
) (
    input  logic clk,
    output logic done,
    output int   checks,
    output int   bad
);
    localparam int BT = 32 / L;

    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_word;
    logic [2:0]   in_kind;
    logic [3:0]   in_tag;
    logic         throttle;
    logic [L-1:0] lane_data;
    logic         lane_strobe;
    logic         lane_first;
    logic [2:0]   lane_kind;
    logic [3:0]   lane_tag;

    bcast_word_ser #(.LANES(L)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_word     (in_word),
        .in_kind     (in_kind),
        .in_tag      (in_tag),
        .throttle    (throttle),
        .lane_data   (lane_data),
        .lane_strobe (lane_strobe),
        .lane_first  (lane_first),
        .lane_kind   (lane_kind),
        .lane_tag    (lane_tag)
    );

    int unsigned rng;
    bit          m_busy;
    int          m_beat;
    logic [31:0] m_word;
    logic [2:0]  m_kind;
    logic [3:0]  m_tag;
    int          p0_accepts;

    function automatic int unsigned next_rng(input int unsigned s);
        int unsigned x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string req, input string what, input int cyc,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s L=%0d cyc=%0d actual=%h expected=%h", req, what, L, cyc, act, exp);
        end
    endtask

    initial begin
        longint      mask;
        logic [31:0] e_data;
        logic        e_ready;
        done       = 1'b0;
        checks     = 0;
        bad        = 0;
        rng        = SEED;
        m_busy     = 1'b0;
        m_beat     = 0;
        m_word     = '0;
        m_kind     = '0;
        m_tag      = '0;
        p0_accepts = 0;
        mask       = (64'd1 << L) - 1;
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_word    = 32'hdead_beef;
        in_kind    = 3'd4;
        in_tag     = 4'hf;
        throttle   = 1'b0;

        // R1: quiet outputs during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "reset in_ready", -1, 32'(in_ready), 32'd1);
        chk("R1", "reset strobe", -1, 32'(lane_strobe), 32'd0);
        chk("R1", "reset first", -1, 32'(lane_first), 32'd0);
        chk("R1", "reset data", -1, 32'(lane_data), 32'd0);
        chk("R1", "reset kind/tag", -1, {25'd0, lane_kind, lane_tag}, 32'd0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < N; cyc++) begin
            int ph;
            @(negedge clk);
            ph  = cyc / 200;
            rng = next_rng(rng);
            // payload changes every cycle to exercise R9
            in_word = rng ^ (rng << 7);
            in_kind = 3'(rng % 5);
            in_tag  = 4'(rng >> 9);
            unique case (ph)
                0: begin in_valid = 1'b1;     throttle = 1'b0; end
                1: begin in_valid = rng[20];  throttle = 1'b0; end
                2: begin in_valid = 1'b1;     throttle = (cyc % 3 == 1); end
                3: begin in_valid = rng[21] | rng[22]; throttle = rng[23] & rng[24]; end
                default: begin in_valid = 1'b1; throttle = ((cyc / 7) % 2) == 1; end
            endcase
            #1;
            e_ready = !m_busy || ((m_beat == BT - 1) && !throttle);
            e_data  = m_busy ? 32'((longint'(m_word) >> (m_beat * L)) & mask) : 32'd0;
            chk("R8", "in_ready", cyc, 32'(in_ready), 32'(e_ready));
            chk("R4", "strobe", cyc, 32'(lane_strobe), 32'(m_busy && !throttle));
            chk(throttle ? "R5" : "R3", "lane_data", cyc, 32'(lane_data), e_data);
            chk("R7", "first", cyc, 32'(lane_first), 32'(m_busy && m_beat == 0));
            chk("R6", "kind", cyc, 32'(lane_kind), m_busy ? 32'(m_kind) : 32'd0);
            chk("R9", "tag", cyc, 32'(lane_tag), m_busy ? 32'(m_tag) : 32'd0);
            // model advances with this cycle's inputs
            if (ph == 0 && in_valid && e_ready) p0_accepts++;
            if (m_busy && !throttle) begin
                if (m_beat == BT - 1) m_busy = 1'b0;
                else m_beat++;
            end
            if (in_valid && e_ready) begin
                m_busy = 1'b1;
                m_beat = 0;
                m_word = in_word;
                m_kind = in_kind;
                m_tag  = in_tag;
            end
            if (cyc == 199) begin
                chk("R2", "accepts in free-running phase", cyc, 32'(p0_accepts), 32'(200 / BT));
            end
        end
        done = 1'b1;
    end
endmodule

module bcast_word_ser_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic done_n;
    logic done_w;
    int   chk_n;
    int   bad_n;
    int   chk_w;
    int   bad_w;
    int   wd_bad;

    bcast_word_ser_run #(.L(8),  .SEED(32'h1234_5678), .N(1000)) u_run_n (
        .clk (clk), .done (done_n), .checks (chk_n), .bad (bad_n)
    );

    bcast_word_ser_run #(.L(32), .SEED(32'h0bad_cafe), .N(1000)) u_run_w (
        .clk (clk), .done (done_w), .checks (chk_w), .bad (bad_w)
    );

    initial begin
        wd_bad = 0;
        fork
            begin
                wait (done_n && done_w);
            end
            begin
                repeat (20000) @(posedge clk);
            end
        join_any
        disable fork;
        if (!(done_n && done_w)) begin
            wd_bad = 1;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", chk_n + chk_w + wd_bad, bad_n + bad_w + wd_bad);
        $finish;
    end
endmodule